// File: doc/BRIEF.md
# Signed-Digit to Two's Complement Converter

This block turns a number held as a string of redundant signed digits into an ordinary two's complement integer. Such strings come out of carry-free adders and recoded multipliers. The digit string arrives as one packed vector of small signed fields, and the converted value leaves on a single output. The conversion is the only place in the block where a carry travels across the whole word. The positive digits form one unsigned vector and the magnitudes of the negative digits form a second one. The output is the first vector minus the second.

Three outputs come straight from the digit pattern, with no carry arithmetic: the zero flag, the sign flag and the negated digit string. The zero flag holds because the all-zero string is the only way to write zero. The sign flag is taken from the most significant non-zero digit. Negation flips the sign of every digit on its own. A further flag reports any field that holds a code outside the legal digit set.

The block is purely combinational. It has two parameters: the radix (2 or 4) and the digit count.

Top module: `sd_to_binary`

## Requirements
- R1: `binOut` equals the sum of digit_i × RADIX^i as a two's complement number of NDIG×log2(RADIX)+1 bits. For legal inputs the value stays exact over the full range, from −(RADIX^NDIG−1) to +(RADIX^NDIG−1).
- R2: Digit i sits at bits [i×DW +: DW] of `digitsIn`, and digit 0 is the least significant. Each field is a two's complement number. DW is 3 for radix 4, where the legal digits are −3 to +3, and 2 for radix 2, where the legal digits are −1, 0 and +1.
- R3: `isZero` is high exactly when every digit field is all zeros. When it is high, `binOut` is zero.
- R4: `isNeg` gives the sign of the most significant non-zero digit: 1 means negative. It is 0 when all digits are zero.
- R5: `digitErr` is high exactly when some field holds the most negative code of its width: 2'b10 in radix 2, or 3'b100 in radix 4.
- R6: When `negateEn` is 1, each field of `digitsOut` is the two's complement negation of the matching input field. The value of `digitsOut` is therefore the negative of the input value.
- R7: When `negateEn` is 0, `digitsOut` equals `digitsIn` bit for bit.
- R8: An input of all maximum positive digits gives RADIX^NDIG−1. An input of all maximum negative digits gives −(RADIX^NDIG−1).
- R9: For legal inputs, `isNeg` equals the top bit of `binOut`. For legal inputs that are not all zero, `binOut` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digitsIn | input | NDIG×DW | Packed signed-digit operand, digit 0 in the low field |
| negateEn | input | 1 | Selects the negated digit string on `digitsOut` |
| binOut | output | NDIG×log2(RADIX)+1 | Two's complement value of `digitsIn` |
| isNeg | output | 1 | Sign of the most significant non-zero digit |
| isZero | output | 1 | All digit fields are zero |
| digitErr | output | 1 | Some field holds an illegal code |
| digitsOut | output | NDIG×DW | Input digits, or the same digits with each sign flipped |

## Verification
The assertions that tie the sign flag to the top bit of `binOut`, and non-zero digits to a non-zero value, assume that every field is legal. They are gated on `digitErr` being low, because an illegal code lets the subtraction and the sign scan disagree.

The random stimulus draws each digit uniformly from the legal set. Illegal codes appear only in directed vectors, and those vectors check nothing except the error flag. A radix-2 instance is swept over every legal digit string. A radix-4 instance is driven at random and with the extreme strings.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  // Strobes the control half hands to the datapath half
  typedef struct packed {
    logic flipSigns;   // drive negated digits on the digit output
    logic allZero;     // digit string is the unique zero pattern
  } sdStrobes_t;

  // Field width of one digit for a supported radix
  function automatic int digitWidth(input int radix);
    return (radix == 4) ? 3 : 2;
  endfunction

  // Binary weight bits one digit position spans
  function automatic int bitsPerDigit(input int radix);
    return (radix == 4) ? 2 : 1;
  endfunction

endpackage

// File: rtl/sdc_control.sv
module sdc_control
  import sdc_pkg::*;
#(
  parameter int RADIX = 4,
  parameter int NDIG  = 8
) (
  input  logic [NDIG*digitWidth(RADIX)-1:0] digitsIn,
  input  logic                              negateEn,
  output sdStrobes_t                        strobes,
  output logic                              isNeg,
  output logic                              isZero,
  output logic                              digitErr
);

  localparam int DW = digitWidth(RADIX);
  localparam logic [DW-1:0] BAD_CODE = {1'b1, {(DW-1){1'b0}}};

  logic [NDIG-1:0] digNonZero;
  logic [NDIG-1:0] digNeg;
  logic [NDIG-1:0] digBad;

  // Per-digit pattern flags, no arithmetic across digits
  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [DW-1:0] field;
    assign field         = digitsIn[i*DW +: DW];
    assign digNonZero[i] = |field;
    assign digNeg[i]     = field[DW-1];
    assign digBad[i]     = (field == BAD_CODE);
  end

  // Priority scan: higher digits overwrite lower ones, so the most
  // significant non-zero digit decides the sign
  logic signAcc;
  always_comb begin
    signAcc = 1'b0;
    for (int i = 0; i < NDIG; i++) begin
      if (digNonZero[i]) signAcc = digNeg[i];
    end
  end

  assign isNeg    = signAcc;
  assign isZero   = ~|digNonZero;
  assign digitErr = |digBad;

  assign strobes.flipSigns = negateEn;
  assign strobes.allZero   = ~|digNonZero;

  always_comb begin
    // R4
    neg_not_zero_chk: assert (!(isNeg && isZero));
  end

endmodule

// File: rtl/sdc_datapath.sv
module sdc_datapath
  import sdc_pkg::*;
#(
  parameter int RADIX = 4,
  parameter int NDIG  = 8
) (
  input  logic [NDIG*digitWidth(RADIX)-1:0]     digitsIn,
  input  sdStrobes_t                            strobes,
  output logic [NDIG*bitsPerDigit(RADIX):0]     binOut,
  output logic [NDIG*digitWidth(RADIX)-1:0]     digitsOut
);

  localparam int DW   = digitWidth(RADIX);
  localparam int BW   = bitsPerDigit(RADIX);
  localparam int VW   = NDIG * BW;
  localparam int OUTW = VW + 1;

  logic [VW-1:0] posVec;
  logic [VW-1:0] negVec;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [DW-1:0] field;
    logic [DW-1:0] flipped;
    assign field   = digitsIn[i*DW +: DW];
    assign flipped = -field;
    // positive digits go to one vector, magnitudes of negative ones to the other
    assign posVec[i*BW +: BW] = field[DW-1] ? '0 : field[BW-1:0];
    assign negVec[i*BW +: BW] = field[DW-1] ? flipped[BW-1:0] : '0;
    // negation is a per-digit sign flip, no carry between digits
    assign digitsOut[i*DW +: DW] = strobes.flipSigns ? flipped : field;
  end

  // The single carry-propagating operation of the block
  logic [OUTW-1:0] diff;
  assign diff   = {1'b0, posVec} - {1'b0, negVec};
  assign binOut = diff;

  always_comb begin
    // R3
    zero_value_chk: assert (!strobes.allZero || (binOut == '0));
  end

endmodule

// File: rtl/sd_to_binary.sv
module sd_to_binary
  import sdc_pkg::*;
#(
  parameter int RADIX = 4,
  parameter int NDIG  = 8
) (
  input  logic [NDIG*digitWidth(RADIX)-1:0] digitsIn,
  input  logic                              negateEn,
  output logic [NDIG*bitsPerDigit(RADIX):0] binOut,
  output logic                              isNeg,
  output logic                              isZero,
  output logic                              digitErr,
  output logic [NDIG*digitWidth(RADIX)-1:0] digitsOut
);

  localparam int OUTW = NDIG * bitsPerDigit(RADIX) + 1;

  sdStrobes_t strobes;

  sdc_control #(.RADIX(RADIX), .NDIG(NDIG)) ctrl_i (
    .digitsIn (digitsIn),
    .negateEn (negateEn),
    .strobes  (strobes),
    .isNeg    (isNeg),
    .isZero   (isZero),
    .digitErr (digitErr)
  );

  sdc_datapath #(.RADIX(RADIX), .NDIG(NDIG)) dp_i (
    .digitsIn  (digitsIn),
    .strobes   (strobes),
    .binOut    (binOut),
    .digitsOut (digitsOut)
  );

  always_comb begin
    // R9
    sign_match_chk: assert (digitErr || (isNeg == binOut[OUTW-1]));
    // R9
    nonzero_value_chk: assert (digitErr || isZero || (binOut != '0));
  end

endmodule

// File: tb/sd_to_binary_tb_top.sv
module sd_to_binary_tb_top;

  localparam int CLK_PERIOD = 10;

  // radix-4 instance, 8 digits
  localparam int N4 = 8;
  localparam int W4 = N4 * 3;
  localparam int O4 = N4 * 2 + 1;
  // radix-2 instance, 5 digits
  localparam int N2 = 5;
  localparam int W2 = N2 * 2;
  localparam int O2 = N2 + 1;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [W4-1:0] din4;
  logic          neg4;
  logic [O4-1:0] bin4;
  logic          isNeg4, isZero4, err4;
  logic [W4-1:0] dout4;

  logic [W2-1:0] din2;
  logic          neg2;
  logic [O2-1:0] bin2;
  logic          isNeg2, isZero2, err2;
  logic [W2-1:0] dout2;

  sd_to_binary #(.RADIX(4), .NDIG(N4)) dut_i (
    .digitsIn(din4), .negateEn(neg4), .binOut(bin4), .isNeg(isNeg4),
    .isZero(isZero4), .digitErr(err4), .digitsOut(dout4));

  sd_to_binary #(.RADIX(2), .NDIG(N2)) dut2_i (
    .digitsIn(din2), .negateEn(neg2), .binOut(bin2), .isNeg(isNeg2),
    .isZero(isZero2), .digitErr(err2), .digitsOut(dout2));

  function automatic int val4(input logic [W4-1:0] v);
    int acc = 0;
    for (int i = N4 - 1; i >= 0; i--) acc = acc * 4 + int'($signed(v[i*3 +: 3]));
    return acc;
  endfunction

  function automatic int val2(input logic [W2-1:0] v);
    int acc = 0;
    for (int i = N2 - 1; i >= 0; i--) acc = acc * 2 + int'($signed(v[i*2 +: 2]));
    return acc;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Drive a legal radix-4 vector and check every output
  task automatic run4(input logic [W4-1:0] v, input logic ng);
    int e;
    @(posedge clk);
    din4 = v; neg4 = ng;
    @(negedge clk);
    e = val4(v);
    chk("R1 value r4", int'($signed(bin4)), e);
    chk("R3 zero r4", int'(isZero4), int'(e == 0));
    chk("R4 sign r4", int'(isNeg4), int'(e < 0));
    chk("R5 no error r4", int'(err4), 0);
    if (ng) chk("R6 negated value r4", val4(dout4), -e);
    else    chk("R7 passthrough r4", int'(dout4 == v), 1);
  endtask

  task automatic run2(input logic [W2-1:0] v, input logic ng);
    int e;
    @(posedge clk);
    din2 = v; neg2 = ng;
    @(negedge clk);
    e = val2(v);
    chk("R1 value r2", int'($signed(bin2)), e);
    chk("R3 zero r2", int'(isZero2), int'(e == 0));
    chk("R4 sign r2", int'(isNeg2), int'(e < 0));
    chk("R5 no error r2", int'(err2), 0);
    if (ng) chk("R6 negated value r2", val2(dout2), -e);
    else    chk("R7 passthrough r2", int'(dout2 == v), 1);
  endtask

  function automatic logic [W4-1:0] rand4();
    logic [W4-1:0] v;
    for (int i = 0; i < N4; i++) begin
      int d = int'($urandom_range(6, 0)) - 3;
      v[i*3 +: 3] = 3'(d);
    end
    return v;
  endfunction

  initial begin
    din4 = '0; neg4 = 1'b0; din2 = '0; neg2 = 1'b0;
    void'($urandom(32'd575));

    // zero string on both instances
    run4('0, 1'b0);
    run2('0, 1'b1);

    // R8 extremes, radix 4: 4^8-1 = 65535
    run4({N4{3'b011}}, 1'b0);
    run4({N4{3'b101}}, 1'b1);
    // R8 extremes, radix 2: 2^5-1 = 31
    run2({N2{2'b01}}, 1'b0);
    run2({N2{2'b11}}, 1'b0);

    // R4 sign taken from top non-zero digit, lower digits of opposite sign
    run4({3'b001, {(N4-1){3'b101}}}, 1'b0);
    run4({3'b000, 3'b111, {(N4-2){3'b011}}}, 1'b0);

    // exhaustive radix-2: every legal string, both negate settings
    for (int c = 0; c < 243; c++) begin
      logic [W2-1:0] v;
      int r = c;
      for (int i = 0; i < N2; i++) begin
        v[i*2 +: 2] = 2'(r % 3 - 1);
        r = r / 3;
      end
      run2(v, c[0]);
    end

    // random radix-4 strings
    for (int n = 0; n < 400; n++) run4(rand4(), 1'($urandom_range(1, 0)));

    // R5 illegal codes, error flag only
    for (int p = 0; p < N4; p++) begin
      logic [W4-1:0] v = rand4();
      v[p*3 +: 3] = 3'b100;
      @(posedge clk); din4 = v; neg4 = 1'b0;
      @(negedge clk);
      chk("R5 illegal r4", int'(err4), 1);
    end
    for (int p = 0; p < N2; p++) begin
      logic [W2-1:0] v = '0;
      v[p*2 +: 2] = 2'b10;
      @(posedge clk); din2 = v; neg2 = 1'b0;
      @(negedge clk);
      chk("R5 illegal r2", int'(err2), 1);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule